// File: doc/BRIEF.md
# Interval Timer with Event-Paced Transfer Request

This block is a general-purpose interval counter that sits on a simple synchronous register bus. Software programs a start value and a mode, then sets the run bit. The counter either stops after one expiry or reloads and repeats. It can count down from the start value to zero or up from zero to the start value. Three options extend this basic behaviour: counting can wait for an external trigger pulse, the count can be latched at each expiry, and a second comparison value can raise its own event.

There are two event sources: expiry and compare. Each one sets a sticky raw flag. Software clears a flag by writing a one to its bit in the clear register. The interrupt line is the OR of the raw flags that the mask register enables. Every event also produces a one-cycle request for a memory-transfer engine, whatever the mask. A transfer engine set to move a fixed burst per request can therefore be paced by the timer period.

Top module: `gp_timer`

## Requirements
- R1: After reset every register reads zero, and `irq` and `dma_req` are low.
- R2: The mode register holds these fields: bits 1:0 select the mode (1 = one-shot, 2 = periodic), bit 2 sets up-count, bit 3 waits for a trigger, bit 4 enables the snapshot and bit 5 enables compare. When the run bit (CTRL bit 0) is set while counting down, the counter loads the start value and decrements once per clock. When it reaches zero an expiry occurs and, in periodic mode, it reloads the start value, so the period is start+1 cycles. Clearing the run bit freezes the count.
- R3: In one-shot mode the expiry clears the run bit, and the counter stays at its final value.
- R4: With up-count set, the counter starts at 0, expires on reaching the start value and, in periodic mode, restarts at 0.
- R5: With wait-for-trigger set, the counter holds its loaded value after the run bit is set until a one-cycle `trig_in` pulse. It takes its first step one cycle after that pulse.
- R6: With snapshot set, the snapshot register receives the count in the cycle the expiry is flagged. Without it, the snapshot register keeps its old value.
- R7: With compare set, a counter value equal to the compare register sets raw bit 1 on the next clock.
- R8: Raw status (bit 0 expiry, bit 1 compare) reads the same whatever the mask. The masked status register and `irq` reflect only the raw bits that are also set in the mask register.
- R9: Writing a 1 to a bit of the clear register clears that raw bit, and writing 0 leaves it unchanged. A new event in the same cycle as a clear keeps the bit set.
- R10: `dma_req` is high for exactly the one cycle after each event, even when every mask bit is zero.
- R11: While the run bit is set, writes to the mode, start value and compare registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address: 0 ctrl, 1 mode, 2 start value, 3 compare, 4 mask, 5 raw, 6 masked, 7 clear, 8 count, 9 snapshot |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| trig_in | input | 1 | Start trigger pulse for wait mode |
| irq | output | 1 | Masked interrupt |
| dma_req | output | 1 | One-cycle transfer request per event |

## Verification
A counter that skips or repeats a step moves the expiry by at least one cycle. This shows at once as a raw flag, `dma_req` pulse or count readback in the wrong cycle, so expiries are checked at the exact cycle on both sides. A stuck active flag shows up within one step, either as a count that keeps moving after a one-shot expiry or after the run bit is cleared, or as a count that moves before the trigger pulse. Status corruption shows up on the next bus read. To expose it, clear writes are timed to land on an event cycle and zero writes are issued to prove they leave the bits alone.

// File: rtl/gpt_pkg.sv
`timescale 1ns/1ps
package gpt_pkg;
   localparam logic [3:0] A_CTRL  = 4'd0;
   localparam logic [3:0] A_MODE  = 4'd1;
   localparam logic [3:0] A_LOAD  = 4'd2;
   localparam logic [3:0] A_CMP   = 4'd3;
   localparam logic [3:0] A_MASK  = 4'd4;
   localparam logic [3:0] A_RAW   = 4'd5;
   localparam logic [3:0] A_MIS   = 4'd6;
   localparam logic [3:0] A_CLR   = 4'd7;
   localparam logic [3:0] A_VALUE = 4'd8;
   localparam logic [3:0] A_SNAP  = 4'd9;

   localparam logic [1:0] KIND_ONESHOT  = 2'd1;
   localparam logic [1:0] KIND_PERIODIC = 2'd2;

   localparam int N_EV   = 2;
   localparam int EV_TMO = 0;
   localparam int EV_CMP = 1;
   localparam int CFG_W  = 6;

   typedef struct packed {
      logic       cmp_on;
      logic       snap_on;
      logic       wait_trg;
      logic       up;
      logic [1:0] kind;
   } cfg_t;
endpackage

// File: rtl/gpt_regs.sv
`timescale 1ns/1ps
module gpt_regs
   import gpt_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [N_EV-1:0]   raw,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  snap,
   input  logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              en,
   output cfg_t              cfg,
   output logic [CNT_W-1:0]  load,
   output logic [CNT_W-1:0]  cmp_val,
   output logic [N_EV-1:0]   mask,
   output logic              start,
   output logic              stop,
   output logic [N_EV-1:0]   clr
);
   logic hit_ctrl, hit_mode, hit_load, hit_cmp, hit_mask, hit_clr;

   assign hit_ctrl = we && (addr == ADDR_W'(A_CTRL));
   assign hit_mode = we && (addr == ADDR_W'(A_MODE));
   assign hit_load = we && (addr == ADDR_W'(A_LOAD));
   assign hit_cmp  = we && (addr == ADDR_W'(A_CMP));
   assign hit_mask = we && (addr == ADDR_W'(A_MASK));
   assign hit_clr  = we && (addr == ADDR_W'(A_CLR));

   assign start = hit_ctrl &&  wdata[0] && !en;
   assign stop  = hit_ctrl && !wdata[0] &&  en;
   assign clr   = hit_clr ? wdata[N_EV-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en      <= 1'b0;
         cfg     <= '0;
         load    <= '0;
         cmp_val <= '0;
         mask    <= '0;
      end else begin
         if (done)       en <= 1'b0;
         else if (start) en <= 1'b1;
         else if (stop)  en <= 1'b0;
         if (!en) begin
            if (hit_mode) cfg     <= cfg_t'(wdata[CFG_W-1:0]);
            if (hit_load) load    <= wdata[CNT_W-1:0];
            if (hit_cmp)  cmp_val <= wdata[CNT_W-1:0];
         end
         if (hit_mask) mask <= wdata[N_EV-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(A_CTRL))       rdata = DATA_W'(en);
      else if (addr == ADDR_W'(A_MODE))  rdata = DATA_W'(cfg);
      else if (addr == ADDR_W'(A_LOAD))  rdata = DATA_W'(load);
      else if (addr == ADDR_W'(A_CMP))   rdata = DATA_W'(cmp_val);
      else if (addr == ADDR_W'(A_MASK))  rdata = DATA_W'(mask);
      else if (addr == ADDR_W'(A_RAW))   rdata = DATA_W'(raw);
      else if (addr == ADDR_W'(A_MIS))   rdata = DATA_W'(raw & mask);
      else if (addr == ADDR_W'(A_VALUE)) rdata = DATA_W'(cnt);
      else if (addr == ADDR_W'(A_SNAP))  rdata = DATA_W'(snap);
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   AST_CFG_LOCK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(load));   // R11
   AST_CFG_LOCK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(cfg));    // R11
endmodule

// File: rtl/gpt_counter.sv
`timescale 1ns/1ps
module gpt_counter
   import gpt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter bit SNAP_EN = 1'b1,
   parameter bit CMP_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             en,
   input  cfg_t             cfg,
   input  logic [CNT_W-1:0] load,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             trig,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] snap,
   output logic [N_EV-1:0]  ev,
   output logic             done
);
   logic             active;
   logic             tmo;
   logic             oneshot;
   logic [CNT_W-1:0] restart;

   assign oneshot = (cfg.kind == KIND_ONESHOT);
   assign restart = cfg.up ? '0 : load;
   assign tmo     = active && (cfg.up ? (cnt == load) : (cnt == '0));
   assign done    = tmo && oneshot;
   assign ev[EV_TMO] = tmo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (start) begin
         cnt    <= restart;
         active <= !cfg.wait_trg;
      end else if (stop) begin
         active <= 1'b0;
      end else if (en && !active && cfg.wait_trg && trig) begin
         active <= 1'b1;
      end else if (active) begin
         if (tmo) begin
            if (oneshot) active <= 1'b0;
            else         cnt    <= restart;
         end else begin
            cnt <= cfg.up ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
         end
      end
   end

   generate
      if (SNAP_EN) begin : g_snap
         logic [CNT_W-1:0] snap_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                 snap_q <= '0;
            else if (tmo && cfg.snap_on) snap_q <= cnt;
         end
         assign snap = snap_q;
      end else begin : g_nosnap
         assign snap = '0;
      end
      if (CMP_EN) begin : g_cmp
         assign ev[EV_CMP] = active && cfg.cmp_on && (cnt == cmp_val);
      end else begin : g_nocmp
         assign ev[EV_CMP] = 1'b0;
      end
   endgenerate

   AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !active);                                   // R3
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !active && cfg.wait_trg) |=> $stable(cnt));   // R5
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt <= load));                           // R2
endmodule

// File: rtl/gpt_status.sv
`timescale 1ns/1ps
module gpt_status
   import gpt_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_EV-1:0] ev,
   input  logic [N_EV-1:0] clr,
   input  logic [N_EV-1:0] mask,
   output logic [N_EV-1:0] raw,
   output logic            irq,
   output logic            dma
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw <= '0;
         dma <= 1'b0;
      end else begin
         raw <= (raw & ~clr) | ev;
         dma <= |ev;
      end
   end

   assign irq = |(raw & mask);

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev[EV_TMO] |=> raw[EV_TMO]);              // R9
   AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[EV_TMO] && !clr[EV_TMO]) |=> raw[EV_TMO]);   // R9
   AST_DMA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev) |=> dma);                           // R10
   AST_DMA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(|ev) |=> !dma);                         // R10
endmodule

// File: rtl/gp_timer.sv
`timescale 1ns/1ps
module gp_timer
   import gpt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4,
   parameter bit SNAP_EN = 1'b1,
   parameter bit CMP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              trig_in,
   output logic              irq,
   output logic              dma_req
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("gp_timer: CNT_W must be in 2..DATA_W");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("gp_timer: ADDR_W must be at least 4");
   end
   if (DATA_W < CFG_W) begin : g_bad_data
      $error("gp_timer: DATA_W too narrow for the mode register");
   end

   logic             en, start, stop, done;
   cfg_t             cfg;
   logic [CNT_W-1:0] load, cmp_val, cnt, snap;
   logic [N_EV-1:0]  mask, clr, ev, raw;

   gpt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
      .raw(raw), .cnt(cnt), .snap(snap), .done(done), .rdata(bus_rdata),
      .en(en), .cfg(cfg), .load(load), .cmp_val(cmp_val), .mask(mask),
      .start(start), .stop(stop), .clr(clr)
   );

   gpt_counter #(.CNT_W(CNT_W), .SNAP_EN(SNAP_EN), .CMP_EN(CMP_EN)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .en(en), .cfg(cfg),
      .load(load), .cmp_val(cmp_val), .trig(trig_in), .cnt(cnt), .snap(snap),
      .ev(ev), .done(done)
   );

   gpt_status u_stat (
      .clk(clk), .rst_n(rst_n), .ev(ev), .clr(clr), .mask(mask),
      .raw(raw), .irq(irq), .dma(dma_req)
   );
endmodule

// File: tb/tb_gp_timer.sv
`timescale 1ns/1ps
module tb_gp_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        trig_in = 1'b0;
   logic        irq, dma_req;
   int          total = 0;
   int          bad = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   gp_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
      .irq(irq), .dma_req(dma_req)
   );

   localparam logic [3:0] CTRL = 0, MODE = 1, LOAD = 2, CMP = 3, MASK = 4,
                          RAW = 5, MIS = 6, CLR = 7, VALUE = 8, SNAP = 9;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1;
      bus_we = 1'b0;
   endtask

   task automatic rchk(input string req, input logic [3:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 10; i++) rchk("R1 reg", 4'(i), 32'd0);
      chk("R1 irq", {31'd0, irq}, 0);
      chk("R1 dma", {31'd0, dma_req}, 0);
   endtask

   task automatic t_periodic_down;
      wr(LOAD, 5); wr(MODE, 2); wr(CTRL, 1);            // edge E
      rchk("R2 loaded", VALUE, 5);
      tick(5);                                          // E+5
      rchk("R2 at zero", VALUE, 0);
      rchk("R2 no early expiry", RAW, 0);
      chk("R10 no early dma", {31'd0, dma_req}, 0);
      tick(1);                                          // E+6
      rchk("R2 reload", VALUE, 5);
      rchk("R8 raw unmasked", RAW, 1);
      chk("R10 dma with mask 0", {31'd0, dma_req}, 1);
      chk("R8 irq masked off", {31'd0, irq}, 0);
      wr(MASK, 1);                                      // E+7
      chk("R10 dma one cycle", {31'd0, dma_req}, 0);
      chk("R8 irq on", {31'd0, irq}, 1);
      rchk("R8 masked status", MIS, 1);
      tick(4);                                          // E+11
      wr(CLR, 1);                                       // E+12 new event
      rchk("R9 event beats clear", RAW, 1);
      wr(CLR, 0);
      rchk("R9 zero write no effect", RAW, 1);
      wr(CLR, 1);                                       // E+14
      rchk("R9 clear", RAW, 0);
      chk("R8 irq drops", {31'd0, irq}, 0);
      wr(CTRL, 0);                                      // E+15
      tick(10);
      rchk("R2 frozen", VALUE, 3);
      rchk("R2 no event when stopped", RAW, 0);
      wr(MASK, 0);
   endtask

   task automatic t_lock;
      wr(LOAD, 7); wr(CTRL, 1);
      wr(LOAD, 9); wr(MODE, 5);
      rchk("R11 load locked", LOAD, 7);
      rchk("R11 mode locked", MODE, 2);
      wr(CTRL, 0);
      wr(LOAD, 9);
      rchk("R11 load free", LOAD, 9);
      wr(CLR, 3);
   endtask

   task automatic t_oneshot_up;
      wr(LOAD, 4); wr(MODE, 21); wr(CTRL, 1);           // E
      rchk("R4 starts at 0", VALUE, 0);
      tick(4);
      rchk("R4 reaches start value", VALUE, 4);
      rchk("R3 still running", CTRL, 1);
      tick(1);                                          // E+5
      rchk("R3 run bit cleared", CTRL, 0);
      rchk("R4 expiry flag", RAW, 1);
      rchk("R6 snapshot", SNAP, 4);
      chk("R10 dma oneshot", {31'd0, dma_req}, 1);
      tick(5);
      rchk("R3 stays stopped", VALUE, 4);
      wr(CLR, 1);
   endtask

   task automatic t_periodic_up;
      wr(LOAD, 3); wr(MODE, 6); wr(CTRL, 1);
      tick(3);
      rchk("R4 top", VALUE, 3);
      tick(1);
      rchk("R4 restart at 0", VALUE, 0);
      rchk("R4 flag", RAW, 1);
      rchk("R6 no snapshot when off", SNAP, 4);
      wr(CTRL, 0);
      wr(CLR, 1);
   endtask

   task automatic t_wait;
      wr(LOAD, 4); wr(MODE, 10); wr(CTRL, 1);
      rchk("R5 loaded", VALUE, 4);
      tick(6);
      rchk("R5 holds before trigger", VALUE, 4);
      rchk("R5 no event", RAW, 0);
      @(negedge clk); trig_in = 1'b1;
      @(posedge clk); #1; trig_in = 1'b0;
      rchk("R5 trigger edge", VALUE, 4);
      tick(1);
      rchk("R5 first step", VALUE, 3);
      tick(4);
      rchk("R5 expiry", RAW, 1);
      rchk("R5 reload", VALUE, 4);
      wr(CTRL, 0);
      wr(CLR, 1);
   endtask

   task automatic t_compare;
      wr(MASK, 2); wr(LOAD, 6); wr(CMP, 2); wr(MODE, 34); wr(CTRL, 1);   // E
      tick(4);
      rchk("R7 at compare", VALUE, 2);
      rchk("R7 not yet", RAW, 0);
      tick(1);
      rchk("R7 compare flag", RAW, 2);
      chk("R10 dma on compare", {31'd0, dma_req}, 1);
      chk("R8 irq via compare", {31'd0, irq}, 1);
      tick(2);
      rchk("R7 both flags", RAW, 3);
      rchk("R8 masked only compare", MIS, 2);
      wr(CTRL, 0);
      wr(CLR, 3);
      rchk("R9 clear both", RAW, 0);
      chk("R8 irq cleared", {31'd0, irq}, 0);
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_periodic_down();
      t_lock();
      t_oneshot_up();
      t_periodic_up();
      t_wait();
      t_compare();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule